// File: doc/BRIEF.md
# Tightly coupled memory address router

This block sits between a processor's load/store port and the external bus. It holds two local memories, one for instructions and one for data, and steers each byte, halfword or word access to one of them or to the external bus. A memory is selected when the access address falls inside that memory's current window. Window bounds and enables come from the control register file as plain inputs, so software can move either window at run time.

The instruction window is tested first. An address that lies in both windows goes to the instruction memory. The block also aligns read data. A word read at an address that is not word aligned returns the containing word rotated. A halfword read at an odd address returns the containing halfword with its two bytes swapped. The same alignment is applied to data that comes back from the external bus.

The processor raises a one-cycle request while `cpu_busy` is low and then waits for `cpu_done`. A local access completes one cycle after it is accepted. An external access is held on the bus until the bus signals ready.

Top module: `tcm_route_unit`

## Requirements
- R1: An address inside both enabled windows is routed to the instruction memory.
- R2: An address matches a window when base <= address <= end; both the base and the end are included, and base-1 and end+1 are not.
- R3: A window whose enable input is low matches no address, and its accesses go to the other window or to the external bus.
- R4: The instruction memory is indexed by address bits [IT_IDX_W-1:0] and the data memory by bits [DT_IDX_W-1:0]. Higher address bits inside a window are ignored, so addresses that differ only above the index alias.
- R5: Size encoding is 2'b00 byte, 2'b01 halfword, 2'b10 word. A word write ignores address bits [1:0]. A halfword write ignores bit 0 and writes byte lanes 1:0 or 3:2 by bit 1. A byte write uses lane [1:0]. Data is taken from the low bits of `cpu_wdata` and stored little-endian.
- R6: A word read returns the aligned word rotated right by 8*address[1:0]. This applies to local and external reads.
- R7: A halfword read returns the aligned halfword in bits [15:0], byte-swapped when address bit 0 is set. A byte read returns the addressed byte in bits [7:0]. Upper bits are zero.
- R8: An access outside both windows raises `ext_req` in the next cycle with unchanged address, size, direction and write data. These stay stable until `ext_ready`. `cpu_done` is asserted in the cycle where `ext_req` and `ext_ready` are both high. The bus returns the containing aligned word on its natural byte lanes.
- R9: A local access asserts `cpu_done` in the cycle after acceptance, with no external request. `cpu_busy` is high from acceptance until completion, and requests made while it is high are ignored.
- R10: After reset both memories read as zero, and `cpu_busy`, `cpu_done` and `ext_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| itcm_on | input | 1 | Instruction window enable |
| itcm_lo | input | AW | Instruction window base (inclusive) |
| itcm_hi | input | AW | Instruction window end (inclusive) |
| dtcm_on | input | 1 | Data window enable |
| dtcm_lo | input | AW | Data window base (inclusive) |
| dtcm_hi | input | AW | Data window end (inclusive) |
| cpu_req | input | 1 | Access request, taken when cpu_busy is low |
| cpu_we | input | 1 | 1 = write |
| cpu_size | input | 2 | 00 byte, 01 halfword, 10 word |
| cpu_addr | input | AW | Byte address |
| cpu_wdata | input | 32 | Write data, low-aligned |
| cpu_busy | output | 1 | An accepted access is in progress |
| cpu_done | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Aligned read data, valid with cpu_done |
| ext_req | output | 1 | External access pending |
| ext_we | output | 1 | External write |
| ext_size | output | 2 | External access size |
| ext_addr | output | AW | External byte address |
| ext_wdata | output | 32 | External write data |
| ext_ready | input | 1 | External access finishes this cycle |
| ext_rdata | input | 32 | Containing aligned word from the bus |

## Verification
The bench builds the router with IT_IDX_W=8 and DT_IDX_W=7, which gives 256-byte and 128-byte memories. The windows are set larger than the memories and made to overlap. With that setup, index aliasing, the priority region, both inclusive edges and the fall-through to the bus can all be reached in a few dozen accesses. The bus responder adds wait states, so the hold-until-ready behaviour and the alignment of returned external data are exercised.

// File: rtl/tcm_route_unit.sv
module tcm_route_unit #(
  parameter int AW       = 32,
  parameter int IT_IDX_W = 12,
  parameter int DT_IDX_W = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          itcm_on,
  input  logic [AW-1:0] itcm_lo,
  input  logic [AW-1:0] itcm_hi,
  input  logic          dtcm_on,
  input  logic [AW-1:0] dtcm_lo,
  input  logic [AW-1:0] dtcm_hi,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [1:0]    cpu_size,
  input  logic [AW-1:0] cpu_addr,
  input  logic [31:0]   cpu_wdata,
  output logic          cpu_busy,
  output logic          cpu_done,
  output logic [31:0]   cpu_rdata,
  output logic          ext_req,
  output logic          ext_we,
  output logic [1:0]    ext_size,
  output logic [AW-1:0] ext_addr,
  output logic [31:0]   ext_wdata,
  input  logic          ext_ready,
  input  logic [31:0]   ext_rdata
);
  localparam int IT_WORDS = 1 << (IT_IDX_W - 2);
  localparam int DT_WORDS = 1 << (DT_IDX_W - 2);

  typedef enum logic [1:0] {S_IDLE, S_TCM, S_EXT} st_t;
  st_t st;

  logic [31:0] imem [IT_WORDS];
  logic [31:0] dmem [DT_WORDS];

  logic [31:0]   rd_q, wdata_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    size_q;
  logic          we_q;
  logic [3:0]    be;
  logic [31:0]   wlane;

  wire accept = cpu_req && (st == S_IDLE);
  wire hit_i  = itcm_on && (cpu_addr >= itcm_lo) && (cpu_addr <= itcm_hi);
  wire hit_d  = dtcm_on && (cpu_addr >= dtcm_lo) && (cpu_addr <= dtcm_hi);
  wire sel_d  = hit_d && !hit_i;
  wire [IT_IDX_W-3:0] iw = cpu_addr[IT_IDX_W-1:2];
  wire [DT_IDX_W-3:0] dw = cpu_addr[DT_IDX_W-1:2];

  always_comb begin
    case (cpu_size)
      2'b00:   begin be = 4'b0001 << cpu_addr[1:0]; wlane = {4{cpu_wdata[7:0]}};  end
      2'b01:   begin be = cpu_addr[1] ? 4'b1100 : 4'b0011; wlane = {2{cpu_wdata[15:0]}}; end
      default: begin be = 4'b1111; wlane = cpu_wdata; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < IT_WORDS; i++) imem[i] <= '0;
    end else if (accept && cpu_we && hit_i) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) imem[iw][8*b +: 8] <= wlane[8*b +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DT_WORDS; i++) dmem[i] <= '0;
    end else if (accept && cpu_we && sel_d) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) dmem[dw][8*b +: 8] <= wlane[8*b +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      rd_q    <= '0;
      wdata_q <= '0;
      addr_q  <= '0;
      size_q  <= '0;
      we_q    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st      <= (hit_i || hit_d) ? S_TCM : S_EXT;
          rd_q    <= hit_i ? imem[iw] : dmem[dw];
          wdata_q <= cpu_wdata;
          addr_q  <= cpu_addr;
          size_q  <= cpu_size;
          we_q    <= cpu_we;
        end
        S_TCM:   st <= S_IDLE;
        S_EXT:   if (ext_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  function automatic logic [31:0] align_rd(input logic [31:0] w, input logic [1:0] a,
                                            input logic [1:0] sz);
    logic [63:0] dbl;
    logic [15:0] h;
    dbl = {w, w} >> {a, 3'b000};
    h   = a[1] ? w[31:16] : w[15:0];
    case (sz)
      2'b00:   return {24'h0, dbl[7:0]};
      2'b01:   return a[0] ? {16'h0, h[7:0], h[15:8]} : {16'h0, h};
      default: return dbl[31:0];
    endcase
  endfunction

  assign cpu_busy  = (st != S_IDLE);
  assign cpu_done  = (st == S_TCM) || ((st == S_EXT) && ext_ready);
  assign cpu_rdata = align_rd((st == S_EXT) ? ext_rdata : rd_q, addr_q[1:0], size_q);
  assign ext_req   = (st == S_EXT);
  assign ext_we    = we_q;
  assign ext_size  = size_q;
  assign ext_addr  = addr_q;
  assign ext_wdata = wdata_q;
endmodule

// File: rtl/tcm_route_unit_chk.sv
module tcm_route_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          itcm_on,
  input logic [AW-1:0] itcm_lo,
  input logic [AW-1:0] itcm_hi,
  input logic          dtcm_on,
  input logic [AW-1:0] dtcm_lo,
  input logic [AW-1:0] dtcm_hi,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic [1:0]    cpu_size,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_busy,
  input logic          cpu_done,
  input logic          ext_req,
  input logic          ext_we,
  input logic [1:0]    ext_size,
  input logic [AW-1:0] ext_addr,
  input logic [31:0]   ext_wdata,
  input logic          ext_ready
);
  wire take  = cpu_req && !cpu_busy;
  wire in_i  = itcm_on && (cpu_addr >= itcm_lo) && (cpu_addr <= itcm_hi);
  wire in_d  = dtcm_on && (cpu_addr >= dtcm_lo) && (cpu_addr <= dtcm_hi);

  p_local_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take && (in_i || in_d) |=> cpu_done && !ext_req);

  p_miss_forward_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take && !in_i && !in_d |=> ext_req && ext_addr == $past(cpu_addr)
                               && ext_size == $past(cpu_size) && ext_we == $past(cpu_we));

  p_ext_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && !ext_ready |=> ext_req && $stable(ext_addr) && $stable(ext_wdata));

  p_ext_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && ext_ready |-> cpu_done);

  p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> cpu_busy);

  p_end_inclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take && itcm_on && cpu_addr == itcm_hi |=> !ext_req);
endmodule

bind tcm_route_unit tcm_route_unit_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .itcm_on(itcm_on), .itcm_lo(itcm_lo), .itcm_hi(itcm_hi),
  .dtcm_on(dtcm_on), .dtcm_lo(dtcm_lo), .dtcm_hi(dtcm_hi),
  .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
  .cpu_busy(cpu_busy), .cpu_done(cpu_done),
  .ext_req(ext_req), .ext_we(ext_we), .ext_size(ext_size), .ext_addr(ext_addr),
  .ext_wdata(ext_wdata), .ext_ready(ext_ready)
);

// File: tb/tcm_route_unit_tb_top.sv
`timescale 1ns/1ps
module tcm_route_unit_tb_top;
  localparam int IW = 8;
  localparam int DW = 7;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        itcm_on, dtcm_on;
  logic [31:0] itcm_lo, itcm_hi, dtcm_lo, dtcm_hi;
  logic        cpu_req, cpu_we;
  logic [1:0]  cpu_size;
  logic [31:0] cpu_addr, cpu_wdata;
  logic        cpu_busy, cpu_done;
  logic [31:0] cpu_rdata;
  logic        ext_req, ext_we;
  logic [1:0]  ext_size;
  logic [31:0] ext_addr, ext_wdata;
  logic        ext_ready;
  logic [31:0] ext_rdata;

  tcm_route_unit #(.AW(32), .IT_IDX_W(IW), .DT_IDX_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .itcm_on(itcm_on), .itcm_lo(itcm_lo), .itcm_hi(itcm_hi),
    .dtcm_on(dtcm_on), .dtcm_lo(dtcm_lo), .dtcm_hi(dtcm_hi),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .ext_req(ext_req), .ext_we(ext_we), .ext_size(ext_size), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_ready(ext_ready), .ext_rdata(ext_rdata)
  );

  int checks = 0;
  int errors = 0;

  logic [7:0] itm [1 << IW];
  logic [7:0] dtm [1 << DW];
  logic [7:0] ext_m [logic [31:0]];

  typedef struct {
    logic [31:0] v;
    string       tag;
    bit          rd;
  } exp_t;
  exp_t sb [$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic int route(input logic [31:0] a);
    if (itcm_on && a >= itcm_lo && a <= itcm_hi) return 1;
    if (dtcm_on && a >= dtcm_lo && a <= dtcm_hi) return 2;
    return 0;
  endfunction

  function automatic logic [7:0] rb(input int r, input logic [31:0] a);
    if (r == 1) return itm[a[IW-1:0]];
    if (r == 2) return dtm[a[DW-1:0]];
    if (ext_m.exists(a)) return ext_m[a];
    return 8'h00;
  endfunction

  task automatic wb(input int r, input logic [31:0] a, input logic [7:0] d);
    if (r == 1) itm[a[IW-1:0]] = d;
    else if (r == 2) dtm[a[DW-1:0]] = d;
    else ext_m[a] = d;
  endtask

  function automatic logic [31:0] ref_read(input logic [31:0] a, input logic [1:0] sz);
    int r;
    logic [31:0] al, w;
    logic [63:0] dbl;
    logic [15:0] h;
    r = route(a);
    case (sz)
      2'b00: return {24'h0, rb(r, a)};
      2'b01: begin
        al = {a[31:1], 1'b0};
        h  = {rb(r, al + 1), rb(r, al)};
        if (a[0]) h = {h[7:0], h[15:8]};
        return {16'h0, h};
      end
      default: begin
        al  = {a[31:2], 2'b00};
        w   = {rb(r, al + 3), rb(r, al + 2), rb(r, al + 1), rb(r, al)};
        dbl = {w, w} >> (8 * a[1:0]);
        return dbl[31:0];
      end
    endcase
  endfunction

  task automatic ref_write(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    int r;
    logic [31:0] al;
    r = route(a);
    case (sz)
      2'b00: wb(r, a, d[7:0]);
      2'b01: begin
        al = {a[31:1], 1'b0};
        wb(r, al, d[7:0]); wb(r, al + 1, d[15:8]);
      end
      default: begin
        al = {a[31:2], 2'b00};
        for (int b = 0; b < 4; b++) wb(r, al + b, d[8*b +: 8]);
      end
    endcase
  endtask

  task automatic access(input bit we, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] d, input string tag);
    int r;
    exp_t e;
    r = route(a);
    e.tag = tag;
    e.rd  = !we;
    e.v   = we ? 32'h0 : ref_read(a, sz);
    sb.push_back(e);
    if (we) ref_write(a, sz, d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
    if (r != 0) begin
      check(cpu_done && !ext_req, {tag, " R9 local done after one cycle"},
            {30'h0, ext_req, cpu_done}, 32'h1);
    end else begin
      check(ext_req && ext_addr == a && ext_size == sz && ext_we == we &&
            (!we || ext_wdata == d), {tag, " R8 forwarded request"}, ext_addr, a);
    end
    while (!cpu_done) @(negedge clk);
    @(negedge clk);
  endtask

  int wcnt = 0;
  initial begin
    ext_ready = 1'b0;
    ext_rdata = '0;
    forever begin
      @(posedge clk);
      #1;
      if (ext_ready) begin
        ext_ready = 1'b0;
      end else if (ext_req) begin
        if (wcnt == 2) begin
          logic [31:0] al;
          wcnt = 0;
          al = {ext_addr[31:2], 2'b00};
          ext_rdata = {rb(0, al + 3), rb(0, al + 2), rb(0, al + 1), rb(0, al)};
          ext_ready = 1'b1;
        end else begin
          wcnt++;
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cpu_done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R9 unexpected completion", 32'h1, 32'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (e.rd) check(cpu_rdata == e.v, e.tag, cpu_rdata, e.v);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << IW); i++) itm[i] = 8'h00;
    for (int i = 0; i < (1 << DW); i++) dtm[i] = 8'h00;
    rst_n = 1'b0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_size = 2'b00; cpu_addr = '0; cpu_wdata = '0;
    itcm_on = 1'b1; itcm_lo = 32'h1000; itcm_hi = 32'h13FF;
    dtcm_on = 1'b1; dtcm_lo = 32'h1300; dtcm_hi = 32'h17FF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cpu_busy && !cpu_done && !ext_req, "R10 idle after reset",
          {29'h0, cpu_busy, cpu_done, ext_req}, 32'h0);

    access(0, 2'b10, 32'h1000, 0, "R10 instruction memory cleared");
    access(0, 2'b10, 32'h1700, 0, "R10 data memory cleared");

    access(1, 2'b10, 32'h1000, 32'h44332211, "R5 word write");
    access(1, 2'b10, 32'h1006, 32'h88776655, "R5 misaligned word write");
    access(1, 2'b01, 32'h100B, 32'h0000BBAA, "R5 odd halfword write");
    access(1, 2'b00, 32'h100D, 32'h000000CC, "R5 byte write");
    access(0, 2'b10, 32'h1004, 0, "R5 word write lands aligned");
    access(0, 2'b10, 32'h1008, 0, "R5 halfword lanes");
    access(0, 2'b10, 32'h100C, 0, "R5 byte lane");

    access(0, 2'b10, 32'h1001, 0, "R6 rotate by 8");
    access(0, 2'b10, 32'h1003, 0, "R6 rotate by 24");
    access(0, 2'b10, 32'h1006, 0, "R6 rotate by 16");
    access(0, 2'b01, 32'h100A, 0, "R7 even halfword");
    access(0, 2'b01, 32'h100B, 0, "R7 odd halfword swapped");
    access(0, 2'b01, 32'h1001, 0, "R7 odd halfword low lane");
    access(0, 2'b00, 32'h100D, 0, "R7 byte read");
    access(0, 2'b00, 32'h1002, 0, "R7 byte read lane 2");

    access(0, 2'b10, 32'h1100, 0, "R4 instruction alias");
    access(1, 2'b10, 32'h1204, 32'hA5A5_0F0F, "R4 aliased write");
    access(0, 2'b10, 32'h1004, 0, "R4 alias readback");

    access(1, 2'b10, 32'h1300, 32'hDEADBEEF, "R1 overlap write");
    access(0, 2'b10, 32'h1000, 0, "R1 overlap went to instruction memory");
    access(1, 2'b00, 32'h13FF, 32'h5A, "R2 end byte write");
    access(0, 2'b00, 32'h13FF, 0, "R2 end byte read");
    access(1, 2'b10, 32'h1400, 32'h01020304, "R2 past instruction end");
    access(1, 2'b00, 32'h17FF, 32'h77, "R2 data end byte");
    access(0, 2'b10, 32'h17FC, 0, "R2 data end readback");
    access(1, 2'b10, 32'h1800, 32'h0BADF00D, "R2 past data end");
    access(0, 2'b00, 32'h0FFF, 0, "R2 below base");
    access(0, 2'b10, 32'h1800, 0, "R2 external readback");

    access(1, 2'b10, 32'h2000, 32'hCAFEF00D, "R8 external write");
    access(0, 2'b10, 32'h2000, 0, "R8 external read");
    access(0, 2'b10, 32'h2002, 0, "R6 external rotate");
    access(0, 2'b01, 32'h2001, 0, "R7 external odd halfword");
    access(0, 2'b00, 32'h2003, 0, "R7 external byte");
    access(1, 2'b01, 32'h2006, 32'h1234, "R8 external halfword write");

    itcm_on = 1'b0;
    access(0, 2'b10, 32'h1000, 0, "R3 disabled instruction window");
    access(0, 2'b10, 32'h1300, 0, "R3 overlap now data memory");
    dtcm_on = 1'b0;
    access(0, 2'b10, 32'h1400, 0, "R3 disabled data window");
    dtcm_on = 1'b1;
    access(0, 2'b10, 32'h1400, 0, "R3 re-enabled data window");

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R9 all completions seen", sb.size(), 32'h0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule